// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This block performs an 8-bit add-with-carry or subtract-with-borrow on an accumulator value and an operand. A decimal-mode input switches the arithmetic from plain binary to packed BCD, in which each 4-bit digit is corrected on its own and the correction ripples a carry (or borrow) into the next digit. A variant input selects between two flag conventions. The legacy one derives zero and negative from the uncorrected binary result. The revised one derives them from the final corrected result and asks the surrounding sequencer for one extra cycle whenever decimal mode is active.

The arithmetic is purely combinational. Its results and flags pass through a single register stage, so each operation's outputs appear one clock after its inputs are sampled. The digit count is a parameter; the default of two digits gives the 8-bit datapath. Operand digits above 9 are not rejected. Their result is whatever the per-digit correction yields.

Top module: `bcd_addsub`

## Requirements
- R1: While rst_n is low, every output register is cleared: res_o is 0 and neg_o, ovf_o, zero_o, carry_o and xcyc_o are 0, whatever the inputs.
- R2: With dec_i=0 and sub_i=0, res_o is (a_i + m_i + carry_i) mod 256, and carry_o is 1 exactly when that sum exceeds 255.
- R3: With dec_i=0 and sub_i=0, ovf_o is 1 exactly when the signed sum of a_i, m_i and carry_i lies outside -128..127.
- R4: With dec_i=0 and sub_i=1, res_o is (a_i - m_i - (1 - carry_i)) mod 256, carry_o is 1 when no borrow occurs, and ovf_o flags signed overflow of that difference.
- R5: With dec_i=1 and sub_i=0, the low digit is a_i[3:0] + m_i[3:0] + carry_i. When that is 10 or more, 10 is removed and 1 is carried into the high-digit sum a_i[7:4] + m_i[7:4].
- R6: In decimal add, when the high-digit sum is 10 or more, 10 is removed and carry_o is 1, otherwise carry_o is 0. res_o holds the high digit in bits 7:4 and the low digit in bits 3:0, each kept to 4 bits.
- R7: In decimal add, ovf_o is 1 when a_i[7] equals m_i[7] and bit 3 of the high-digit sum before its correction differs from m_i[7].
- R8: With dec_i=1 and sub_i=1, the low digit is a_i[3:0] - m_i[3:0] + carry_i - 1. If negative, 10 is added and 1 is borrowed from the high digit a_i[7:4] - m_i[7:4]. If the high digit is negative, 10 is added and carry_o is 0, otherwise carry_o is 1. The digits are packed as in R6.
- R9: In decimal subtract, ovf_o equals the value a binary subtract (R4) of the same inputs gives.
- R10: With cmos_i=0 (legacy variant), zero_o and neg_o come from the binary result of the same operation, even when dec_i=1. xcyc_o is 0.
- R11: With cmos_i=1 (revised variant), zero_o is 1 when res_o is 0 and neg_o equals res_o[7]. xcyc_o equals dec_i.
- R12: With dec_i=0, both variants give identical res_o, carry_o, ovf_o, zero_o and neg_o, and xcyc_o is 0.
- R13: Outputs reflect the inputs sampled at the preceding rising clk edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| a_i | input | 8 | Accumulator operand |
| m_i | input | 8 | Memory/second operand |
| carry_i | input | 1 | Carry flag in (1 = no borrow for subtract) |
| dec_i | input | 1 | 1 selects packed-BCD arithmetic |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| cmos_i | input | 1 | 0 = legacy flag variant, 1 = revised variant |
| res_o | output | 8 | Registered result |
| neg_o | output | 1 | Registered negative flag |
| ovf_o | output | 1 | Registered overflow flag |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry flag out |
| xcyc_o | output | 1 | Registered extra-cycle request |

## Verification
Every result and flag is due exactly one rising edge after its inputs are applied. The bench therefore drives each vector on a falling edge and compares all six outputs on the next falling edge, after one capturing edge and before the following one. For the latency requirement it also changes the inputs and samples again before any rising edge, expecting the outputs of the previous vector. The checker assertions compare current outputs with the inputs one cycle in the past, which matches the same single-register delay.

// File: rtl/asu_pkg.sv
package asu_pkg;

    localparam int DIGIT_W = 4;
    localparam int CELL_W  = DIGIT_W + 2;
    localparam logic [CELL_W-1:0] RADIX = CELL_W'(10);

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef enum logic {
        FLAG_LEGACY  = 1'b0,
        FLAG_REVISED = 1'b1
    } flavor_e;

endpackage

// File: rtl/asu_bin_core.sv
module asu_bin_core
    import asu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic         cin_i,
    input  op_e          op_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] opnd;
    logic [W:0]   wide;

    always_comb begin
        // subtract is add of the inverted operand; carry-in doubles as not-borrow
        opnd   = (op_i == OP_SUB) ? ~m_i : m_i;
        wide   = {1'b0, a_i} + {1'b0, opnd} + {{W{1'b0}}, cin_i};
        res_o  = wide[MSB:0];
        cout_o = wide[W];
        ovf_o  = (a_i[MSB] == opnd[MSB]) && (wide[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/asu_dec_digit.sv
module asu_dec_digit
    import asu_pkg::*;
(
    input  logic [DIGIT_W-1:0] a_i,
    input  logic [DIGIT_W-1:0] m_i,
    input  op_e                op_i,
    input  logic               cin_i,
    output logic [DIGIT_W-1:0] dig_o,
    output logic [DIGIT_W-1:0] raw_o,
    output logic               cout_o
);
    logic [CELL_W-1:0] sum;
    logic [CELL_W-1:0] dif;
    logic [CELL_W-1:0] fix;

    always_comb begin
        sum = {2'b00, a_i} + {2'b00, m_i} + {{(CELL_W-1){1'b0}}, cin_i};
        dif = {2'b00, a_i} - {2'b00, m_i} - {{(CELL_W-1){1'b0}}, cin_i};
        if (op_i == OP_SUB) begin
            // cin/cout mean borrow here
            cout_o = dif[CELL_W-1];
            fix    = cout_o ? dif + RADIX : dif;
            raw_o  = dif[DIGIT_W-1:0];
        end else begin
            cout_o = (sum >= RADIX);
            fix    = cout_o ? sum - RADIX : sum;
            raw_o  = sum[DIGIT_W-1:0];
        end
        dig_o = fix[DIGIT_W-1:0];
    end

endmodule

// File: rtl/asu_dec_chain.sv
module asu_dec_chain
    import asu_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic [DIGITS*DIGIT_W-1:0] a_i,
    input  logic [DIGITS*DIGIT_W-1:0] m_i,
    input  logic                      cin_i,
    input  op_e                       op_i,
    output logic [DIGITS*DIGIT_W-1:0] res_o,
    output logic                      cout_o,
    output logic [DIGIT_W-1:0]        top_raw_o
);
    logic [DIGITS:0]        link;
    logic [DIGIT_W-1:0]     raw [DIGITS];

    // flag carry in becomes a borrow for subtract
    assign link[0] = (op_i == OP_SUB) ? ~cin_i : cin_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        asu_dec_digit u_dig (
            .a_i    (a_i[g*DIGIT_W +: DIGIT_W]),
            .m_i    (m_i[g*DIGIT_W +: DIGIT_W]),
            .op_i   (op_i),
            .cin_i  (link[g]),
            .dig_o  (res_o[g*DIGIT_W +: DIGIT_W]),
            .raw_o  (raw[g]),
            .cout_o (link[g+1])
        );
    end

    assign cout_o    = (op_i == OP_SUB) ? ~link[DIGITS] : link[DIGITS];
    assign top_raw_o = raw[DIGITS-1];

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
    import asu_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIGITS*DIGIT_W-1:0] a_i,
    input  logic [DIGITS*DIGIT_W-1:0] m_i,
    input  logic                      carry_i,
    input  logic                      dec_i,
    input  logic                      sub_i,
    input  logic                      cmos_i,
    output logic [DIGITS*DIGIT_W-1:0] res_o,
    output logic                      neg_o,
    output logic                      ovf_o,
    output logic                      zero_o,
    output logic                      carry_o,
    output logic                      xcyc_o
);
    localparam int W   = DIGITS * DIGIT_W;
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         neg;
        logic         ovf;
        logic         zero;
        logic         cy;
        logic         xcyc;
    } out_t;

    out_t    st_d, st_q;
    op_e     op;
    flavor_e flavor;

    logic [W-1:0]       bin_res;
    logic               bin_cy;
    logic               bin_ovf;
    logic [W-1:0]       dec_res;
    logic               dec_cy;
    logic [DIGIT_W-1:0] dec_raw;

    assign op     = op_e'(sub_i);
    assign flavor = flavor_e'(cmos_i);

    asu_bin_core #(.W(W)) u_bin (
        .a_i    (a_i),
        .m_i    (m_i),
        .cin_i  (carry_i),
        .op_i   (op),
        .res_o  (bin_res),
        .cout_o (bin_cy),
        .ovf_o  (bin_ovf)
    );

    asu_dec_chain #(.DIGITS(DIGITS)) u_dec (
        .a_i       (a_i),
        .m_i       (m_i),
        .cin_i     (carry_i),
        .op_i      (op),
        .res_o     (dec_res),
        .cout_o    (dec_cy),
        .top_raw_o (dec_raw)
    );

    always_comb begin
        st_d = '0;
        if (dec_i) begin
            st_d.res = dec_res;
            st_d.cy  = dec_cy;
            if (op == OP_SUB) begin
                st_d.ovf = bin_ovf;
            end else begin
                // sign test on the top digit sum before its correction
                st_d.ovf = (a_i[MSB] == m_i[MSB]) && (m_i[MSB] != dec_raw[DIGIT_W-1]);
            end
        end else begin
            st_d.res = bin_res;
            st_d.cy  = bin_cy;
            st_d.ovf = bin_ovf;
        end

        if (flavor == FLAG_REVISED) begin
            st_d.zero = (st_d.res == '0);
            st_d.neg  = st_d.res[MSB];
            st_d.xcyc = dec_i;
        end else begin
            st_d.zero = (bin_res == '0);
            st_d.neg  = bin_res[MSB];
            st_d.xcyc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o   = st_q.res;
    assign neg_o   = st_q.neg;
    assign ovf_o   = st_q.ovf;
    assign zero_o  = st_q.zero;
    assign carry_o = st_q.cy;
    assign xcyc_o  = st_q.xcyc;

endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_i,
    input logic [W-1:0] m_i,
    input logic         carry_i,
    input logic         dec_i,
    input logic         sub_i,
    input logic         cmos_i,
    input logic [W-1:0] res_o,
    input logic         neg_o,
    input logic         ovf_o,
    input logic         zero_o,
    input logic         carry_o,
    input logic         xcyc_o
);

    // R2
    bin_add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dec_i) && !$past(sub_i)) |->
        ({carry_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(m_i)} + {{W{1'b0}}, $past(carry_i)})));

    // R4
    bin_sub_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dec_i) && $past(sub_i)) |->
        (res_o == ($past(a_i) - $past(m_i) - {{(W-1){1'b0}}, !$past(carry_i)})));

    // R11
    revised_zn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmos_i)) |->
        ((zero_o == (res_o == '0)) && (neg_o == res_o[W-1]) && (xcyc_o == $past(dec_i))));

    // R10
    legacy_no_xcyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cmos_i)) |-> !xcyc_o);

    // R12
    binary_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dec_i)) |->
        ((zero_o == (res_o == '0)) && (neg_o == res_o[W-1]) && !xcyc_o));

endmodule

bind bcd_addsub bcd_addsub_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_i     (a_i),
    .m_i     (m_i),
    .carry_i (carry_i),
    .dec_i   (dec_i),
    .sub_i   (sub_i),
    .cmos_i  (cmos_i),
    .res_o   (res_o),
    .neg_o   (neg_o),
    .ovf_o   (ovf_o),
    .zero_o  (zero_o),
    .carry_o (carry_o),
    .xcyc_o  (xcyc_o)
);

// File: tb/sim_bcd_addsub.sv
module sim_bcd_addsub;

    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_i = '0;
    logic [7:0] m_i = '0;
    logic       carry_i = 1'b0;
    logic       dec_i = 1'b0;
    logic       sub_i = 1'b0;
    logic       cmos_i = 1'b0;
    logic [7:0] res_o;
    logic       neg_o, ovf_o, zero_o, carry_o, xcyc_o;

    int nchk  = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_addsub u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (a_i),
        .m_i     (m_i),
        .carry_i (carry_i),
        .dec_i   (dec_i),
        .sub_i   (sub_i),
        .cmos_i  (cmos_i),
        .res_o   (res_o),
        .neg_o   (neg_o),
        .ovf_o   (ovf_o),
        .zero_o  (zero_o),
        .carry_o (carry_o),
        .xcyc_o  (xcyc_o)
    );

    // expected {res, n, v, z, c, x}
    function automatic logic [12:0] model(input logic [7:0] a, input logic [7:0] m,
                                          input logic c, input logic d,
                                          input logic s, input logic rv);
        int sa, sm, t, sv, lo, hi, pre;
        logic [7:0] bres, r;
        logic bc, bv, fc, fv;
        sa = (a >= 128) ? int'(a) - 256 : int'(a);
        sm = (m >= 128) ? int'(m) - 256 : int'(m);
        if (s) begin
            t  = 256 + int'(a) - int'(m) + int'(c) - 1;
            sv = sa - sm + int'(c) - 1;
        end else begin
            t  = int'(a) + int'(m) + int'(c);
            sv = sa + sm + int'(c);
        end
        bres = t[7:0];
        bc   = (t > 255);
        bv   = (sv < -128) || (sv > 127);
        r = bres; fc = bc; fv = bv;
        if (d && !s) begin
            lo = int'(a & 8'h0f) + int'(m & 8'h0f) + int'(c);
            hi = int'(a >> 4) + int'(m >> 4);
            if (lo >= 10) begin lo -= 10; hi++; end
            pre = hi & 15;
            fc = (hi >= 10);
            if (fc) hi -= 10;
            r  = {hi[3:0], lo[3:0]};
            fv = (m[7] == a[7]) && (m[7] != pre[3]);
        end else if (d && s) begin
            lo = int'(a & 8'h0f) - int'(m & 8'h0f) + int'(c) - 1;
            hi = int'(a >> 4) - int'(m >> 4);
            if (lo < 0) begin lo += 10; hi--; end
            fc = 1'b1;
            if (hi < 0) begin hi += 10; fc = 1'b0; end
            r  = {hi[3:0], lo[3:0]};
            fv = bv;
        end
        if (rv) return {r, r[7], fv, (r == 8'h00), fc, d};
        return {r, bres[7], fv, (bres == 8'h00), fc, 1'b0};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input logic [7:0] a, input logic [7:0] m, input logic c,
                           input logic d, input logic s, input logic rv);
        logic [12:0] e;
        string trc, tv, tzn, tx;
        e = model(a, m, c, d, s, rv);
        if (!d) begin
            trc = s ? "R4" : "R2";
            tv  = s ? "R4" : "R3";
            tzn = "R12";
            tx  = "R12";
        end else if (!s) begin
            trc = (a[3:0] + m[3:0] + 4'(c) >= 10) ? "R5" : "R6";
            tv  = "R7";
            tzn = rv ? "R11" : "R10";
            tx  = rv ? "R11" : "R10";
        end else begin
            trc = "R8";
            tv  = "R9";
            tzn = rv ? "R11" : "R10";
            tx  = rv ? "R11" : "R10";
        end
        check(trc, "res",   int'(res_o),   int'(e[12:5]));
        check(trc, "carry", int'(carry_o), int'(e[1]));
        check(tv,  "ovf",   int'(ovf_o),   int'(e[3]));
        check(tzn, "neg",   int'(neg_o),   int'(e[4]));
        check(tzn, "zero",  int'(zero_o),  int'(e[2]));
        check(tx,  "xcyc",  int'(xcyc_o),  int'(e[0]));
    endtask

    // inputs set on a falling edge, captured on the next rising edge, checked on the following falling edge
    task automatic run(input logic [7:0] a, input logic [7:0] m, input logic c,
                       input logic d, input logic s, input logic rv);
        a_i = a; m_i = m; carry_i = c; dec_i = d; sub_i = s; cmos_i = rv;
        @(negedge clk);
        compare(a, m, c, d, s, rv);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        // R1: reset with busy inputs
        a_i = 8'h99; m_i = 8'h01; carry_i = 1'b1; dec_i = 1'b1; cmos_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "res",   int'(res_o),   0);
        check("R1", "flags", int'({neg_o, ovf_o, zero_o, carry_o, xcyc_o}), 0);
        rst_n = 1'b1;

        // directed corners
        for (int rv = 0; rv < 2; rv++) begin
            run(8'h7f, 8'h01, 1'b0, 1'b0, 1'b0, rv[0]); // R3 signed overflow
            run(8'hff, 8'h00, 1'b1, 1'b0, 1'b0, rv[0]); // R2 wrap to zero
            run(8'h80, 8'h01, 1'b1, 1'b0, 1'b1, rv[0]); // R4 overflow
            run(8'h00, 8'h01, 1'b1, 1'b0, 1'b1, rv[0]); // R4 borrow
            run(8'h09, 8'h01, 1'b0, 1'b1, 1'b0, rv[0]); // R5 low digit fix
            run(8'h58, 8'h46, 1'b1, 1'b1, 1'b0, rv[0]); // R6 both digits fix
            run(8'h99, 8'h01, 1'b0, 1'b1, 1'b0, rv[0]); // R10 R11 zero split
            run(8'h79, 8'h00, 1'b1, 1'b1, 1'b0, rv[0]); // R7
            run(8'h00, 8'h01, 1'b1, 1'b1, 1'b1, rv[0]); // R8 wrap to 99
            run(8'h80, 8'h01, 1'b1, 1'b1, 1'b1, rv[0]); // R9
            run(8'hfc, 8'hfe, 1'b0, 1'b1, 1'b0, rv[0]); // invalid digits
            run(8'h0a, 8'hf0, 1'b0, 1'b1, 1'b1, rv[0]); // invalid digits
        end

        // R13: new inputs must not show before a rising edge
        run(8'h12, 8'h34, 1'b0, 1'b0, 1'b0, 1'b0);
        a_i = 8'h55; m_i = 8'h55; carry_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R13", "res held", int'(res_o), 8'h46);
        @(negedge clk);
        check("R13", "res next", int'(res_o), 8'hab);

        for (int i = 0; i < NRAND; i++) begin
            logic [31:0] rnd;
            logic [7:0] ra, rm;
            rnd = $urandom;
            ra  = rnd[7:0];
            rm  = rnd[15:8];
            if (rnd[20]) begin
                // bias toward valid digits
                ra = {4'(rnd[7:4] % 10), 4'(rnd[3:0] % 10)};
                rm = {4'(rnd[15:12] % 10), 4'(rnd[11:8] % 10)};
            end
            run(ra, rm, rnd[16], rnd[17], rnd[18], rnd[19]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule